// File: doc/BRIEF.md
# Stereo Audio Sample Request Pacer

This block sits in the audio clock domain. It turns a fast master clock into a slow, regular stereo sample strobe. A fixed clock-enable divider first lets one master cycle in every `ENA_DIV` through. A sample counter then counts those enabled cycles and marks every `SAMPLES_PER_PAIR`-th one as a sample tick.

On a sample tick, a small capture state machine latches the 24-bit left word and the 24-bit right word into holding registers on the same clock edge. These registers feed a downstream DAC serializer. In the next master cycle the block drives a one-cycle `taken` acknowledge. This tells the upstream producer that the pair has been consumed and that it must present the next pair before the following tick.

With the defaults, a 49.152 MHz master clock gives a 12.288 MHz enable rate. One pair is consumed every 1024 master cycles, which is 48 kHz. A 16-bit PCM source must supply its words already zero-extended in the low byte, because the DAC works in 24-bit mode. The block passes all 24 bits through unchanged.

The capture state machine has two states:
- `ST_WAIT` holds the registers and keeps `taken` low. The transition *tick* captures both channels and moves to `ST_ACK`.
- `ST_ACK` drives `taken` high for one cycle. The transition *done* returns unconditionally to `ST_WAIT`.

Reset forces `ST_WAIT`.

Top module: `audio_sample_pacer`

## Requirements
- R1: `ena_strobe` is high for exactly one master cycle in every `ENA_DIV` (4). Counting the first cycle after reset release as cycle 0, it is high in cycles 3, 7, 11, and so on.
- R2: A sample tick occurs on every `SAMPLES_PER_PAIR`-th (256th) enabled cycle. The first `taken` pulse is therefore in cycle 1024 after reset release, and consecutive `taken` pulses are exactly 1024 master cycles apart.
- R3: On a tick, `left_out` and `right_out` are both loaded on the same clock edge. They take the values that `left_in` and `right_in` had during the tick cycle, and become visible one cycle later.
- R4: Between ticks, `left_out` and `right_out` hold their values no matter how `left_in` and `right_in` change.
- R5: `taken` is high for exactly one master cycle: the cycle right after the capture edge. It is low in all other cycles.
- R6: All 24 bits pass through unmodified. A zero-extended 16-bit sample (bits 7:0 equal to 0) appears with bits 7:0 still 0 and bits 23:8 equal to the input.
- R7: Synchronous reset clears the divider and sample counters, both holding registers and `taken`. `ena_strobe` is low while reset is held, and after release the timing of R1 and R2 restarts from cycle 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master audio clock |
| rst | input | 1 | Synchronous reset, active high |
| left_in | input | 24 | Left sample presented by the producer |
| right_in | input | 24 | Right sample presented by the producer |
| left_out | output | 24 | Captured left word toward the DAC serializer |
| right_out | output | 24 | Captured right word toward the DAC serializer |
| taken | output | 1 | One-cycle acknowledge that the pair was consumed |
| ena_strobe | output | 1 | Divided clock-enable strobe |

## Verification
Cycles are counted from reset release.
- `ena_strobe` is combinational from the divider count, so it is due in the same cycle as the count: every cycle whose index modulo 4 is 3.
- A tick in cycle 1023 + 1024k shows up one register later. Both holding registers change and `taken` rises in cycle 1024 + 1024k.

The bench samples every output at the falling edge of each cycle and compares it with these arithmetic expectations. It drives a new input pattern after each sample. The expected holding value is therefore exactly the input of the most recent tick cycle, and any capture one cycle early or late shows up as a mismatch. A mid-run reset checks that all outputs clear and that the same schedule restarts from cycle 0.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_ACK  = 1'b1
    } cap_state_t;

endpackage

// File: rtl/pacer_ena_div.sv
// Fixed clock-enable divider: one strobe cycle per ENA_DIV master cycles.
module pacer_ena_div #(
    parameter int ENA_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic ena
);
    localparam int DIV_W = (ENA_DIV > 1) ? $clog2(ENA_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(ENA_DIV - 1);

    logic [DIV_W-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
        end else if (div_cnt == DIV_LAST) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    always_comb begin
        ena = (div_cnt == DIV_LAST);
    end

    // R1: the strobe never lasts two cycles
    assert_ena_single_R1: assert property (@(posedge clk) disable iff (rst)
        ena |=> !ena);

    // R7: the count restarts from zero after reset
    assert_div_reset_R7: assert property (@(posedge clk)
        $past(rst) |-> (div_cnt == '0));

endmodule

// File: rtl/pacer_sample_cnt.sv
// Counts enabled cycles and flags the last one of each sample period.
module pacer_sample_cnt #(
    parameter int SAMPLES_PER_PAIR = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic ena,
    output logic tick
);
    localparam int CNT_W = (SAMPLES_PER_PAIR > 1) ? $clog2(SAMPLES_PER_PAIR) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLES_PER_PAIR - 1);

    logic [CNT_W-1:0] smp_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_cnt <= '0;
        end else if (ena) begin
            if (smp_cnt == CNT_LAST) begin
                smp_cnt <= '0;
            end else begin
                smp_cnt <= smp_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        tick = ena && (smp_cnt == CNT_LAST);
    end

    // R2: the count stays inside its period
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        smp_cnt <= CNT_LAST);

    // R2: the count only moves on enabled cycles
    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !ena |=> $stable(smp_cnt));

endmodule

// File: rtl/pacer_capture_fsm.sv
// Capture state machine: latches both channels on a tick, then acknowledges.
module pacer_capture_fsm
    import pacer_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [DATA_W-1:0] left_in,
    input  logic [DATA_W-1:0] right_in,
    output logic [DATA_W-1:0] left_q,
    output logic [DATA_W-1:0] right_q,
    output logic              taken
);
    cap_state_t state, state_nxt;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_WAIT: if (tick) state_nxt = ST_ACK;   // transition: tick
            ST_ACK:  state_nxt = ST_WAIT;            // transition: done
            default: state_nxt = ST_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_WAIT;
        end else begin
            state <= state_nxt;
        end
    end

    // holding registers: both channels are loaded on one edge
    always_ff @(posedge clk) begin
        if (rst) begin
            left_q  <= '0;
            right_q <= '0;
        end else if (state == ST_WAIT && tick) begin
            left_q  <= left_in;
            right_q <= right_in;
        end
    end

    // output decode
    always_comb begin
        unique case (state)
            ST_WAIT: taken = 1'b0;
            ST_ACK:  taken = 1'b1;
            default: taken = 1'b0;
        endcase
    end

    // R4: holding registers do not move without a tick
    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(left_q) && $stable(right_q)));

    // R3: both channels come from the tick-cycle inputs
    assert_capture_pair_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> ((left_q == $past(left_in)) && (right_q == $past(right_in))));

    // R5: acknowledge lasts a single cycle
    assert_taken_single_R5: assert property (@(posedge clk) disable iff (rst)
        taken |=> !taken);

endmodule

// File: rtl/audio_sample_pacer.sv
// Top: enable divider, sample counter and capture state machine.
module audio_sample_pacer #(
    parameter int ENA_DIV          = 4,
    parameter int SAMPLES_PER_PAIR = 256,
    parameter int DATA_W           = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] left_in,
    input  logic [DATA_W-1:0] right_in,
    output logic [DATA_W-1:0] left_out,
    output logic [DATA_W-1:0] right_out,
    output logic              taken,
    output logic              ena_strobe
);
    localparam int PERIOD = ENA_DIV * SAMPLES_PER_PAIR;
    localparam int GAP_W  = $clog2(PERIOD) + 2;

    logic ena;
    logic tick;

    pacer_ena_div #(
        .ENA_DIV (ENA_DIV)
    ) u_ena_div (
        .clk (clk),
        .rst (rst),
        .ena (ena)
    );

    pacer_sample_cnt #(
        .SAMPLES_PER_PAIR (SAMPLES_PER_PAIR)
    ) u_sample_cnt (
        .clk  (clk),
        .rst  (rst),
        .ena  (ena),
        .tick (tick)
    );

    pacer_capture_fsm #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .left_in  (left_in),
        .right_in (right_in),
        .left_q   (left_out),
        .right_q  (right_out),
        .taken    (taken)
    );

    always_comb begin
        ena_strobe = ena;
    end

    // checker state: cycles since reset release or since the last acknowledge
    logic [GAP_W-1:0] gap_cnt;
    logic             seen_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt  <= '0;
            seen_ack <= 1'b0;
        end else if (taken) begin
            gap_cnt  <= '0;
            seen_ack <= 1'b1;
        end else begin
            gap_cnt  <= gap_cnt + 1'b1;
        end
    end

    // R2: a tick only happens on an enabled cycle
    assert_tick_on_ena_R2: assert property (@(posedge clk) disable iff (rst)
        tick |-> ena);

    // R5: every tick is acknowledged in the next cycle
    assert_tick_acks_R5: assert property (@(posedge clk) disable iff (rst)
        tick |=> taken);

    // R2: first acknowledge one period after reset release
    assert_first_ack_R2: assert property (@(posedge clk) disable iff (rst)
        (taken && !seen_ack) |-> (gap_cnt == GAP_W'(PERIOD)));

    // R2: later acknowledges exactly one period apart
    assert_ack_period_R2: assert property (@(posedge clk) disable iff (rst)
        (taken && seen_ack) |-> (gap_cnt == GAP_W'(PERIOD - 1)));

    // R7: nothing is acknowledged while reset is held
    assert_reset_quiet_R7: assert property (@(posedge clk)
        $past(rst) |-> (!taken && left_out == '0 && right_out == '0));

endmodule

// File: tb/audio_sample_pacer_bench.sv
`timescale 1ns/1ps
module audio_sample_pacer_bench;

    localparam int DW     = 24;
    localparam int DIV    = 4;
    localparam int PERIOD = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] left_in  = '0;
    logic [DW-1:0] right_in = '0;
    logic [DW-1:0] left_out, right_out;
    logic          taken, ena_strobe;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    audio_sample_pacer u_audio_sample_pacer (
        .clk        (clk),
        .rst        (rst),
        .left_in    (left_in),
        .right_in   (right_in),
        .left_out   (left_out),
        .right_out  (right_out),
        .taken      (taken),
        .ena_strobe (ena_strobe)
    );

    function automatic logic [DW-1:0] pat(input int n, input bit side);
        logic [31:0] h;
        h = (n * 32'h0001_9E37) ^ (side ? 32'h00C3_5A17 : 32'h0071_2B4D);
        // every other cycle: a 16-bit sample zero-extended in the low byte
        if (n[0]) return {h[15:0], 8'h00};
        return h[23:0];
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp, input int n);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle=%0d actual=%0h expected=%0h", req, n, act, exp);
        end
    endtask

    task automatic reset_phase(input int cyc);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < cyc; i++) begin
            left_in  = pat(i + 7, 1'b0);
            right_in = pat(i + 9, 1'b1);
            @(negedge clk);
            // R7: outputs cleared and strobe quiet under reset
            check("R7 left", left_out, '0, i);
            check("R7 right", right_out, '0, i);
            check("R7 taken", {23'd0, taken}, '0, i);
            check("R7 ena", {23'd0, ena_strobe}, '0, i);
        end
        rst = 1'b0;
    endtask

    // at entry: negedge in cycle 0 after reset release
    task automatic sweep(input int total);
        logic [DW-1:0] exp_l, exp_r;
        int last_ack;
        exp_l    = '0;
        exp_r    = '0;
        last_ack = -1;
        for (int n = 0; n < total; n++) begin
            // R1: strobe on cycles 3, 7, 11, ...
            check("R1 ena", {23'd0, ena_strobe}, {23'd0, (n % DIV) == DIV - 1}, n);
            // R2/R5: acknowledge one cycle after each tick
            check("R2/R5 taken", {23'd0, taken},
                  {23'd0, (n >= PERIOD) && (n % PERIOD == 0)}, n);
            if (taken) begin
                if (last_ack >= 0)
                    check("R2 gap", DW'(n - last_ack), DW'(PERIOD), n);
                last_ack = n;
            end
            // R3/R4: holding values equal the last tick-cycle inputs
            check("R3/R4 left", left_out, exp_l, n);
            check("R3/R4 right", right_out, exp_r, n);
            if (n >= PERIOD && n % PERIOD == 0 && n[0] == 1'b0) begin
                // R6: low byte of a zero-extended sample stays zero
                check("R6 left low", {16'd0, left_out[7:0]}, '0, n);
            end
            left_in  = pat(n, 1'b0);
            right_in = pat(n, 1'b1);
            if (n % PERIOD == PERIOD - 1) begin
                exp_l = pat(n, 1'b0);
                exp_r = pat(n, 1'b1);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        reset_phase(3);
        sweep(3 * PERIOD + 100);
        reset_phase(4);
        sweep(4 * PERIOD + 50);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 60000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule